// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit resolves the conditional relative jumps of an 8-bit-compatible microcontroller core once the instruction has been decoded and its operands fetched. Each request carries a jump class, the current program counter, the instruction length, a signed 8-bit displacement and the operands that class needs: a tested bit, the accumulator, a pair of compare operands or a loop counter. The unit returns the next program counter, a taken flag, and any side effect the class calls for. That side effect is a cleared bit, a decremented counter or a new carry flag, each with its own write enable.

The unit also returns the number of execution states the jump consumes. The decoder supplies a base not-taken count for the addressing variant. The unit adds an access penalty that depends on the jump class and on where the operand lives: ordinary memory, an I/O port or a peripheral register. A taken jump costs three more states. It costs one more on top of that when execution is internal and the internal destination address is odd.

A single-cycle `start_i` strobe loads a request. All results appear together with a one-cycle `done_o` pulse after the next rising clock edge. They then hold until the next strobe.

Top module: `brc_unit`

## Requirements
- R1: The sequential address is `pc_i + size_i`. When the jump is taken, `next_pc_o` is the sequential address plus `disp_i` sign-extended as two's complement; otherwise it is the sequential address. All arithmetic wraps modulo 2^16.
- R2: Class code 0 (jump on set bit) is taken when `bit_i` is 1. Class code 1 (jump on clear bit) is taken when `bit_i` is 0.
- R3: Class code 2 (jump on set bit and clear it) is taken when `bit_i` is 1. Only in that case does it raise `bit_we_o` with `bit_wd_o` = 0; when `bit_i` is 0, `bit_we_o` stays 0.
- R4: Class code 3 is taken when `acc_i` is 0. Class code 4 is taken when `acc_i` is not 0.
- R5: Class code 5 (compare) raises `cy_we_o`. It sets `cy_o` to 1 when `cmp_a_i < cmp_b_i` compared unsigned and to 0 otherwise, and it is taken when the two operands differ.
- R6: Class code 6 (decrement) raises `cnt_we_o` with `cnt_wd_o` = `cnt_i - 1` (mod 256), and it is taken when that result is not 0. Any write enable that does not belong to the class is 0.
- R7: The not-taken state count is `base_i` plus a penalty, and the taken count is 3 higher. `space_i` encodes the operand location: 0 ordinary, 1 I/O port, 2 peripheral register, 3 treated as ordinary. The penalty is 1 (port) or 2 (peripheral) for classes 0, 1 and 5; 2 or 3 for class 6; 3 or 5 for class 2; and always 0 for classes 3 and 4.
- R8: A taken jump costs one extra state when `int_exec_i`, `dest_int_i` and bit 0 of the jump target are all 1. A jump that is not taken never pays this state.
- R9: A cycle with `start_i` high makes `done_o` high for exactly the following cycle, with all results valid. The results hold unchanged until the next start.
- R10: After reset, `done_o`, `taken_o`, all write enables, `next_pc_o` and `states_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request strobe |
| op_i | input | 3 | Jump class code (0..6) |
| pc_i | input | 16 | Address of the jump instruction |
| size_i | input | 3 | Instruction length in bytes |
| disp_i | input | 8 | Signed relative displacement |
| bit_i | input | 1 | Tested bit value |
| acc_i | input | 8 | Accumulator |
| cmp_a_i | input | 8 | First compare operand |
| cmp_b_i | input | 8 | Second compare operand |
| cnt_i | input | 8 | Counter operand before decrement |
| space_i | input | 2 | Operand location code |
| base_i | input | 4 | Base not-taken state count for the addressing variant |
| int_exec_i | input | 1 | Execution is from internal code memory |
| dest_int_i | input | 1 | Jump target lies in internal code memory |
| done_o | output | 1 | Results valid (one-cycle pulse) |
| next_pc_o | output | 16 | Resolved next program counter |
| taken_o | output | 1 | Jump taken |
| bit_we_o | output | 1 | Write back the tested bit |
| bit_wd_o | output | 1 | Bit write-back value |
| cnt_we_o | output | 1 | Write back the counter |
| cnt_wd_o | output | 8 | Decremented counter |
| cy_we_o | output | 1 | Update the carry flag |
| cy_o | output | 1 | New carry value |
| states_o | output | 5 | Execution states consumed |

## Verification
On every cycle the assertions check the start-to-done pulse timing and that at most one write enable is raised. They also check that a set-and-clear write-back carries 0, that a decrement is taken exactly when its result is nonzero, and that a carry set by a compare always comes with a taken jump. The bench's scenarios are needed for the rest: exact target addresses across displacement sign changes and 16-bit wrap, the unsigned ordering of the compare, and the full penalty table for each class and operand location. They also cover the odd-target state, which must be charged only when execution and destination are both internal and the jump is taken.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [2:0] {
    OP_JSET    = 3'd0,
    OP_JCLR    = 3'd1,
    OP_JSETCLR = 3'd2,
    OP_JACCZ   = 3'd3,
    OP_JACCNZ  = 3'd4,
    OP_CMPJ    = 3'd5,
    OP_DECJ    = 3'd6,
    OP_NONE    = 3'd7
  } brc_op_e;

  typedef enum logic [1:0] {
    SP_PLAIN  = 2'd0,
    SP_PORT   = 2'd1,
    SP_PERIPH = 2'd2,
    SP_RSVD   = 2'd3
  } brc_space_e;

  localparam int unsigned PEN_W = 3;

  // access penalties per class family: {port, peripheral}
  localparam logic [PEN_W-1:0] PEN_TEST_PORT   = 3'd1;
  localparam logic [PEN_W-1:0] PEN_TEST_PERIPH = 3'd2;
  localparam logic [PEN_W-1:0] PEN_DEC_PORT    = 3'd2;
  localparam logic [PEN_W-1:0] PEN_DEC_PERIPH  = 3'd3;
  localparam logic [PEN_W-1:0] PEN_CLR_PORT    = 3'd3;
  localparam logic [PEN_W-1:0] PEN_CLR_PERIPH  = 3'd5;

endpackage

// File: rtl/brc_cond.sv
module brc_cond
  import brc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  brc_op_e           op,
  input  logic              bit_val,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic [DATA_W-1:0] cnt,
  output logic              taken,
  output logic              bit_we,
  output logic              bit_wd,
  output logic              cnt_we,
  output logic [DATA_W-1:0] cnt_wd,
  output logic              cy_we,
  output logic              cy
);

  logic [DATA_W-1:0] cnt_dec;
  assign cnt_dec = cnt - DATA_W'(1);

  always_comb begin
    taken  = 1'b0;
    bit_we = 1'b0;
    bit_wd = 1'b0;
    cnt_we = 1'b0;
    cnt_wd = '0;
    cy_we  = 1'b0;
    cy     = 1'b0;
    unique case (op)
      OP_JSET:    taken = bit_val;
      OP_JCLR:    taken = ~bit_val;
      OP_JSETCLR: begin
        taken  = bit_val;
        bit_we = bit_val;
      end
      OP_JACCZ:   taken = (acc == '0);
      OP_JACCNZ:  taken = (acc != '0);
      OP_CMPJ: begin
        cy_we = 1'b1;
        cy    = (cmp_a < cmp_b);
        taken = (cmp_a != cmp_b);
      end
      OP_DECJ: begin
        cnt_we = 1'b1;
        cnt_wd = cnt_dec;
        taken  = (cnt_dec != '0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DISP_W = 8,
  parameter int unsigned SIZE_W = 3
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [SIZE_W-1:0] size,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   next_pc
);

  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] disp_ext;

  assign seq_pc   = pc + PC_W'(size);
  assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign target   = seq_pc + disp_ext;
  assign next_pc  = taken ? target : seq_pc;

endmodule

// File: rtl/brc_cost.sv
module brc_cost
  import brc_pkg::*;
#(
  parameter int unsigned BASE_W      = 4,
  parameter int unsigned ST_W        = 5,
  parameter int unsigned TAKEN_EXTRA = 3
) (
  input  brc_op_e           op,
  input  brc_space_e        space,
  input  logic [BASE_W-1:0] base,
  input  logic              taken,
  input  logic              int_exec,
  input  logic              dest_int,
  input  logic              target_odd,
  output logic [ST_W-1:0]   states
);

  logic [PEN_W-1:0] pen;
  logic [ST_W-1:0]  nt_cnt;
  logic [ST_W-1:0]  tk_cnt;
  logic             odd_pen;

  always_comb begin
    pen = '0;
    if (space == SP_PORT || space == SP_PERIPH) begin
      unique case (op)
        OP_JSET, OP_JCLR, OP_CMPJ:
          pen = (space == SP_PORT) ? PEN_TEST_PORT : PEN_TEST_PERIPH;
        OP_DECJ:
          pen = (space == SP_PORT) ? PEN_DEC_PORT : PEN_DEC_PERIPH;
        OP_JSETCLR:
          pen = (space == SP_PORT) ? PEN_CLR_PORT : PEN_CLR_PERIPH;
        default: pen = '0;
      endcase
    end
  end

  assign odd_pen = int_exec & dest_int & target_odd;
  assign nt_cnt  = ST_W'(base) + ST_W'(pen);
  assign tk_cnt  = nt_cnt + ST_W'(TAKEN_EXTRA) + ST_W'(odd_pen);
  assign states  = taken ? tk_cnt : nt_cnt;

endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int unsigned PC_W        = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SIZE_W      = 3,
  parameter int unsigned BASE_W      = 4,
  parameter int unsigned ST_W        = 5,
  parameter int unsigned TAKEN_EXTRA = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] disp_i,
  input  logic              bit_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] cmp_a_i,
  input  logic [DATA_W-1:0] cmp_b_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [1:0]        space_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              int_exec_i,
  input  logic              dest_int_i,
  output logic              done_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              bit_we_o,
  output logic              bit_wd_o,
  output logic              cnt_we_o,
  output logic [DATA_W-1:0] cnt_wd_o,
  output logic              cy_we_o,
  output logic              cy_o,
  output logic [ST_W-1:0]   states_o
);

  // reset: asynchronous assertion, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  brc_op_e    op_c;
  brc_space_e space_c;
  assign op_c    = brc_op_e'(op_i);
  assign space_c = brc_space_e'(space_i);

  logic              taken_c, bit_we_c, bit_wd_c, cnt_we_c, cy_we_c, cy_c;
  logic [DATA_W-1:0] cnt_wd_c;
  logic [PC_W-1:0]   target_c, next_pc_c;
  logic [ST_W-1:0]   states_c;

  brc_cond #(.DATA_W(DATA_W)) u_cond (
    .op      (op_c),
    .bit_val (bit_i),
    .acc     (acc_i),
    .cmp_a   (cmp_a_i),
    .cmp_b   (cmp_b_i),
    .cnt     (cnt_i),
    .taken   (taken_c),
    .bit_we  (bit_we_c),
    .bit_wd  (bit_wd_c),
    .cnt_we  (cnt_we_c),
    .cnt_wd  (cnt_wd_c),
    .cy_we   (cy_we_c),
    .cy      (cy_c)
  );

  brc_target #(.PC_W(PC_W), .DISP_W(DATA_W), .SIZE_W(SIZE_W)) u_target (
    .pc      (pc_i),
    .size    (size_i),
    .disp    (disp_i),
    .taken   (taken_c),
    .target  (target_c),
    .next_pc (next_pc_c)
  );

  brc_cost #(.BASE_W(BASE_W), .ST_W(ST_W), .TAKEN_EXTRA(TAKEN_EXTRA)) u_cost (
    .op         (op_c),
    .space      (space_c),
    .base       (base_i),
    .taken      (taken_c),
    .int_exec   (int_exec_i),
    .dest_int   (dest_int_i),
    .target_odd (target_c[0]),
    .states     (states_c)
  );

  // next-state
  logic res_en;
  logic done_d;
  assign res_en = start_i;
  assign done_d = start_i;

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_o <= 1'b0;
    end else begin
      done_o <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      next_pc_o <= '0;
      taken_o   <= 1'b0;
      bit_we_o  <= 1'b0;
      bit_wd_o  <= 1'b0;
      cnt_we_o  <= 1'b0;
      cnt_wd_o  <= '0;
      cy_we_o   <= 1'b0;
      cy_o      <= 1'b0;
      states_o  <= '0;
    end else if (res_en) begin
      next_pc_o <= next_pc_c;
      taken_o   <= taken_c;
      bit_we_o  <= bit_we_c;
      bit_wd_o  <= bit_wd_c;
      cnt_we_o  <= cnt_we_c;
      cnt_wd_o  <= cnt_wd_c;
      cy_we_o   <= cy_we_c;
      cy_o      <= cy_c;
      states_o  <= states_c;
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_i |=> done_o); // R9
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> $past(start_i)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !start_i |=> $stable(next_pc_o) && $stable(states_o)); // R9
  AST_CLR_WRITES_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    bit_we_o |-> (!bit_wd_o && taken_o)); // R3
  AST_DEC_TAKEN_NZ: assert property (@(posedge clk) disable iff (!rst_int_n)
    cnt_we_o |-> (taken_o == (cnt_wd_o != '0))); // R6
  AST_CARRY_IMPLIES_TAKEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cy_we_o && cy_o) |-> taken_o); // R5
  AST_ONE_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({bit_we_o, cnt_we_o, cy_we_o})); // R6
  AST_TAKEN_MIN_COST: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && taken_o) |-> (states_o >= ST_W'(TAKEN_EXTRA))); // R7

endmodule

// File: tb/brc_unit_tb.sv
module brc_unit_tb;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] pc;
    logic [2:0]  size;
    logic [7:0]  disp;
    logic        bitv;
    logic [7:0]  acc;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  cnt;
    logic [1:0]  space;
    logic [3:0]  base;
    logic        ix;
    logic        di;
    logic [15:0] e_pc;
    logic        e_tk;
    logic [4:0]  e_st;
    logic        e_we;
    logic [7:0]  e_wb;
  } vec_t;

  localparam int NV = 14;
  // op pc size disp bit acc a b cnt space base ix di | pc tk st we wb
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h1000, 3'd3, 8'h10, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 4'd2, 1'b0, 1'b0, 16'h1013, 1'b1, 5'd5,  1'b0, 8'h00}, // R2
    '{3'd0, 16'h1000, 3'd3, 8'h10, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 4'd2, 1'b0, 1'b0, 16'h1003, 1'b0, 5'd2,  1'b0, 8'h00}, // R2
    '{3'd1, 16'h2000, 3'd3, 8'hF0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1, 4'd2, 1'b0, 1'b0, 16'h1FF3, 1'b1, 5'd6,  1'b0, 8'h00}, // R1 R2 R7
    '{3'd2, 16'h0100, 3'd3, 8'h04, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 2'd2, 4'd4, 1'b1, 1'b1, 16'h0107, 1'b1, 5'd13, 1'b1, 8'h00}, // R3 R7 R8
    '{3'd2, 16'h0100, 3'd3, 8'h04, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 2'd2, 4'd4, 1'b1, 1'b1, 16'h0103, 1'b0, 5'd9,  1'b0, 8'h00}, // R3
    '{3'd3, 16'hFFFE, 3'd2, 8'h05, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 2'd2, 4'd2, 1'b1, 1'b0, 16'h0005, 1'b1, 5'd5,  1'b0, 8'h00}, // R1 R4 R7
    '{3'd4, 16'hFFFE, 3'd2, 8'h05, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 4'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 5'd2,  1'b0, 8'h00}, // R4
    '{3'd5, 16'h4000, 3'd3, 8'h7F, 1'b0, 8'h00, 8'h03, 8'hC8, 8'h00, 2'd1, 4'd2, 1'b1, 1'b1, 16'h4082, 1'b1, 5'd6,  1'b1, 8'h01}, // R5 R8
    '{3'd5, 16'h4000, 3'd3, 8'h7F, 1'b0, 8'h00, 8'h55, 8'h55, 8'h00, 2'd0, 4'd2, 1'b0, 1'b0, 16'h4003, 1'b0, 5'd2,  1'b1, 8'h00}, // R5
    '{3'd5, 16'h4000, 3'd4, 8'h80, 1'b0, 8'h00, 8'h90, 8'h10, 8'h00, 2'd2, 4'd3, 1'b1, 1'b1, 16'h3F84, 1'b1, 5'd8,  1'b1, 8'h00}, // R1 R5
    '{3'd6, 16'h5000, 3'd3, 8'h20, 1'b0, 8'h00, 8'h00, 8'h00, 8'h01, 2'd1, 4'd3, 1'b0, 1'b0, 16'h5003, 1'b0, 5'd5,  1'b1, 8'h00}, // R6 R7
    '{3'd6, 16'h5000, 3'd2, 8'h01, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 2'd2, 4'd3, 1'b1, 1'b1, 16'h5003, 1'b1, 5'd10, 1'b1, 8'hFF}, // R6 R8
    '{3'd6, 16'h5000, 3'd2, 8'h01, 1'b0, 8'h00, 8'h00, 8'h00, 8'h05, 2'd2, 4'd3, 1'b0, 1'b1, 16'h5003, 1'b1, 5'd9,  1'b1, 8'h04}, // R6 R8
    '{3'd1, 16'h1001, 3'd3, 8'h00, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0, 4'd2, 1'b1, 1'b1, 16'h1004, 1'b0, 5'd2,  1'b0, 8'h00}  // R8
  };

  logic clk, rst_n, start;
  logic [2:0] op; logic [15:0] pc; logic [2:0] size; logic [7:0] disp;
  logic bitv; logic [7:0] acc, ca, cb, cnt; logic [1:0] space; logic [3:0] base;
  logic ix, di;
  logic done, taken, bit_we, bit_wd, cnt_we, cy_we, cy;
  logic [15:0] next_pc; logic [7:0] cnt_wd; logic [4:0] states;

  int n_chk = 0;
  int n_bad = 0;

  brc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .pc_i(pc),
    .size_i(size), .disp_i(disp), .bit_i(bitv), .acc_i(acc), .cmp_a_i(ca),
    .cmp_b_i(cb), .cnt_i(cnt), .space_i(space), .base_i(base),
    .int_exec_i(ix), .dest_int_i(di), .done_o(done), .next_pc_o(next_pc),
    .taken_o(taken), .bit_we_o(bit_we), .bit_wd_o(bit_wd), .cnt_we_o(cnt_we),
    .cnt_wd_o(cnt_wd), .cy_we_o(cy_we), .cy_o(cy), .states_o(states)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    op = v.op; pc = v.pc; size = v.size; disp = v.disp; bitv = v.bitv;
    acc = v.acc; ca = v.a; cb = v.b; cnt = v.cnt; space = v.space;
    base = v.base; ix = v.ix; di = v.di;
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R2";
      3'd2:       return "R3";
      3'd3, 3'd4: return "R4";
      3'd5:       return "R5";
      default:    return "R6";
    endcase
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] wb_act;
    logic       we_act;
    logic       other_we;
    start = 1'b0; rst_n = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    // R10 reset state
    check(done == 1'b0 && taken == 1'b0 && next_pc == 16'h0 && states == 5'd0
          && !bit_we && !cnt_we && !cy_we, "R10", "reset outputs",
          {done, taken, bit_we, cnt_we, cy_we, states, next_pc}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(done == 1'b1, "R9", "done pulse", done, 1);
      check(next_pc == VECS[i].e_pc, "R1", "next pc", next_pc, VECS[i].e_pc);
      check(taken == VECS[i].e_tk, tag_of(VECS[i].op), "taken", taken, VECS[i].e_tk);
      check(states == VECS[i].e_st, "R7", "states", states, VECS[i].e_st);
      case (VECS[i].op)
        3'd2: begin we_act = bit_we; wb_act = {7'd0, bit_wd}; other_we = cnt_we | cy_we; end
        3'd5: begin we_act = cy_we;  wb_act = {7'd0, cy};     other_we = cnt_we | bit_we; end
        3'd6: begin we_act = cnt_we; wb_act = cnt_wd;         other_we = bit_we | cy_we; end
        default: begin we_act = bit_we | cnt_we | cy_we; wb_act = 8'h00; other_we = 1'b0; end
      endcase
      check(we_act == VECS[i].e_we && other_we == 1'b0, tag_of(VECS[i].op),
            "write enable", {we_act, other_we}, {VECS[i].e_we, 1'b0});
      if (VECS[i].e_we)
        check(wb_act == VECS[i].e_wb, tag_of(VECS[i].op), "write data",
              wb_act, VECS[i].e_wb);
    end

    // R9: done lasts one cycle and results hold while inputs change
    drive(VECS[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drive(VECS[1]);
    @(negedge clk);
    check(done == 1'b0, "R9", "done single cycle", done, 0);
    repeat (3) @(negedge clk);
    check(next_pc == 16'h1013 && taken == 1'b1 && states == 5'd5, "R9",
          "hold without start", {next_pc, taken, states}, {16'h1013, 1'b1, 5'd5});

    // R8: odd target with only external execution is not charged
    drive(VECS[11]); ix = 1'b0; di = 1'b1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(states == 5'd9, "R8", "odd target, external exec", states, 9);
    // R7: reserved location code charges nothing
    drive(VECS[0]); space = 2'd3;
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(states == 5'd5, "R7", "reserved location", states, 5);

    // R10: reset in mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && next_pc == 16'h0 && states == 5'd0 && !taken, "R10",
          "reset again", {done, taken, states, next_pc}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule